// File: doc/BRIEF.md
# Queue Doorbell Register File

This block sits on the controller side of a host-driven queue interface. Each queue pair has a submission ring, where the host produces commands, and a completion ring, where the controller produces results. The host reports progress by writing doorbells. It writes a new tail for a submission ring after it has placed commands there. It writes a new head for a completion ring after it has consumed results. The block decodes those writes, range-checks them, and keeps one doorbell register per ring.

The block also keeps the controller's own side of each ring. That is the submission head, moved by the command fetcher, and the completion tail, moved by the completion poster. From these it reports two values per queue: how many commands are waiting to be fetched, and how many completion slots are free. Pair 0 is the admin pair. It exists from reset and takes its sizes straight from the admin attribute inputs. The sizes of the other pairs are loaded through a small configuration port when the pairs are created. All sizes are held in zero-based form, meaning the entry count minus one.

Top module: `doorbell_regfile`

## Requirements
- R1: After reset every doorbell pointer and internal pointer is zero, the error flag is low, every pending count is zero, and the configured sizes of pairs 1 and above are zero (one entry).
- R2: Doorbell slots are spaced by a stride of 4 << DSTRD bytes, counted from byte address 0x1000. Slot 2X holds the submission tail of pair X and slot 2X+1 holds the completion head of pair X.
- R3: A write below 0x1000, or a write that is not a multiple of the stride above it, changes no pointer and does not raise the error flag.
- R4: A doorbell write to a pair index at or above num_q_i raises the error flag and updates nothing.
- R5: A doorbell write whose value is not below the entry count of the target ring (size + 1) raises the error flag and updates nothing.
- R6: The error flag stays high until reset.
- R7: sq_pending_o[X] equals (tail − head) modulo the entry count of submission ring X, including after the tail wraps below the head.
- R8: A pulse on sq_fetch_i[X] advances the submission head by one, wrapping from size to 0. The pulse is ignored when nothing is pending.
- R9: cq_free_o[X] equals size − ((tail − head) modulo the entry count). A pulse on cq_post_i[X] advances the completion tail, and the pulse is ignored when cq_free_o[X] is zero.
- R10: A completion head doorbell write releases consumed slots, so cq_free_o rises by the number of entries consumed.
- R11: Pair 0 sizes follow asq_size_i and acq_size_i. A configuration write to pair Q ≥ 1 loads both of its sizes and clears its four pointers. A configuration write naming pair 0 has no effect.
- R12: rd_data_o returns the doorbell value zero-extended for any decoded slot of an active pair (index below num_q_i), and returns 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | 32 | Read data (combinational) |
| num_q_i | input | QCNT_W | Number of active pairs, including the admin pair |
| asq_size_i | input | PTR_W | Admin submission ring size, zero-based |
| acq_size_i | input | PTR_W | Admin completion ring size, zero-based |
| cfg_we_i | input | 1 | Pair creation strobe |
| cfg_qid_i | input | QIDX_W | Pair being created |
| cfg_sq_size_i | input | PTR_W | New submission ring size, zero-based |
| cfg_cq_size_i | input | PTR_W | New completion ring size, zero-based |
| sq_fetch_i | input | NUM_Q | Per-pair pulse: one command consumed by the fetcher |
| cq_post_i | input | NUM_Q | Per-pair pulse: one completion written by the poster |
| sq_pending_o | output | NUM_Q×(PTR_W+1) | Commands waiting per pair |
| cq_free_o | output | NUM_Q×(PTR_W+1) | Free completion slots per pair |
| err_o | output | 1 | Sticky doorbell error flag |

## Verification
Directed writes first place each doorbell at its stride-scaled slot. Writes at the unscaled 4-byte offset and below the region separate a correct stride decode from a decode that is too coarse or has no lower bound. Fetch and post bursts are run until the ring is empty or full, which shows whether a blocked pulse is really dropped. A tail written below the head exercises the modulo arithmetic. Out-of-range indices and values, placed next to legal ones, separate the two error causes and show that the flag is sticky. A long pseudo-random mix of writes, pulses and reads across three active pairs is then compared every cycle against a behavioural model. This shows whether concurrent doorbell writes, fetch pulses and post pulses on different rings interfere with each other.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  localparam int unsigned DBL_BASE = 32'h1000;

  typedef enum logic {
    SLOT_SQ = 1'b0,
    SLOT_CQ = 1'b1
  } slot_kind_e;
endpackage

// File: rtl/dbl_decode.sv
module dbl_decode
  import dbl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DSTRD  = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output slot_kind_e        kind_o,
  output logic [ADDR_W-1:0] qidx_o
);
  localparam int SHIFT = 2 + DSTRD;

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] slot;
  logic              in_region;
  logic              aligned;

  always_comb begin
    off       = addr_i - ADDR_W'(DBL_BASE);
    in_region = addr_i >= ADDR_W'(DBL_BASE);
    aligned   = off[SHIFT-1:0] == '0;
    slot      = off >> SHIFT;
    hit_o     = in_region && aligned;
    kind_o    = slot_kind_e'(slot[0]);
    qidx_o    = {1'b0, slot[ADDR_W-1:1]};
  end
endmodule

// File: rtl/dbl_ring.sv
// One ring: host-owned pointer (doorbell) plus controller-owned pointer.
module dbl_ring #(
  parameter int PTR_W     = 8,
  parameter bit HOST_PROD = 1'b1  // 1: host produces (submission), 0: host consumes
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] size_i,
  input  logic             clr_i,
  input  logic             host_we_i,
  input  logic [PTR_W-1:0] host_val_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] host_ptr_o,
  output logic [PTR_W:0]   used_o
);
  logic [PTR_W-1:0] host_q, int_q, int_nxt, prod, cons;
  logic [PTR_W:0]   qs;
  logic             can_step;

  always_comb begin
    qs       = {1'b0, size_i} + 1'b1;
    prod     = HOST_PROD ? host_q : int_q;
    cons     = HOST_PROD ? int_q : host_q;
    used_o   = (prod >= cons) ? {1'b0, prod} - {1'b0, cons}
                              : {1'b0, prod} + qs - {1'b0, cons};
    can_step = HOST_PROD ? (used_o != '0) : (used_o < {1'b0, size_i});
    int_nxt  = (int_q == size_i) ? '0 : int_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_q <= '0;
      int_q  <= '0;
    end else if (clr_i) begin
      host_q <= '0;
      int_q  <= '0;
    end else begin
      if (host_we_i) host_q <= host_val_i;
      if (step_i && can_step) int_q <= int_nxt;
    end
  end

  assign host_ptr_o = host_q;

  // R3: doorbell only moves on an accepted write
  a_r3_host_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_we_i && !clr_i |=> $stable(host_ptr_o));

  // R8 / R9: a blocked step leaves the controller pointer alone
  if (HOST_PROD) begin : g_sq_chk
    a_r8_empty_fetch_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i && used_o == '0 && !clr_i |=> $stable(int_q));
  end else begin : g_cq_chk
    a_r9_full_post_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i && used_o == {1'b0, size_i} && !clr_i |=> $stable(int_q));
  end
endmodule

// File: rtl/doorbell_regfile.sv
module doorbell_regfile
  import dbl_pkg::*;
#(
  parameter int NUM_Q  = 4,
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DSTRD  = 0,
  localparam int QIDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int QCNT_W = $clog2(NUM_Q + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [31:0]                 wr_data_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [31:0]                 rd_data_o,
  input  logic [QCNT_W-1:0]           num_q_i,
  input  logic [PTR_W-1:0]            asq_size_i,
  input  logic [PTR_W-1:0]            acq_size_i,
  input  logic                        cfg_we_i,
  input  logic [QIDX_W-1:0]           cfg_qid_i,
  input  logic [PTR_W-1:0]            cfg_sq_size_i,
  input  logic [PTR_W-1:0]            cfg_cq_size_i,
  input  logic [NUM_Q-1:0]            sq_fetch_i,
  input  logic [NUM_Q-1:0]            cq_post_i,
  output logic [NUM_Q-1:0][PTR_W:0]   sq_pending_o,
  output logic [NUM_Q-1:0][PTR_W:0]   cq_free_o,
  output logic                        err_o
);
  logic [PTR_W-1:0] sq_size [NUM_Q];
  logic [PTR_W-1:0] cq_size [NUM_Q];
  logic [PTR_W-1:0] sq_tail [NUM_Q];
  logic [PTR_W-1:0] cq_head [NUM_Q];
  logic [PTR_W:0]   cq_used [NUM_Q];
  logic [NUM_Q-1:0] clr;

  // Write decode
  logic              wr_hit, rd_hit;
  slot_kind_e        wr_kind, rd_kind;
  logic [ADDR_W-1:0] wr_qidx, rd_qidx;

  dbl_decode #(.ADDR_W(ADDR_W), .DSTRD(DSTRD)) u_wr_dec (
    .addr_i(wr_addr_i), .hit_o(wr_hit), .kind_o(wr_kind), .qidx_o(wr_qidx));
  dbl_decode #(.ADDR_W(ADDR_W), .DSTRD(DSTRD)) u_rd_dec (
    .addr_i(rd_addr_i), .hit_o(rd_hit), .kind_o(rd_kind), .qidx_o(rd_qidx));

  logic              wq_ok, wv_ok, wr_good, wr_bad;
  logic [QIDX_W-1:0] wtgt, rtgt;
  logic [PTR_W-1:0]  tgt_size;
  logic              rq_ok;

  always_comb begin
    wq_ok    = (wr_qidx < ADDR_W'(num_q_i)) && (wr_qidx < ADDR_W'(NUM_Q));
    wtgt     = wr_qidx[QIDX_W-1:0];
    tgt_size = '0;
    if (wq_ok) tgt_size = (wr_kind == SLOT_CQ) ? cq_size[wtgt] : sq_size[wtgt];
    wv_ok    = wr_data_i < (32'(tgt_size) + 32'd1);
    wr_good  = wr_en_i && wr_hit && wq_ok && wv_ok;
    wr_bad   = wr_en_i && wr_hit && !(wq_ok && wv_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_o <= 1'b0;
    else if (wr_bad) err_o <= 1'b1;
  end

  // Read port
  always_comb begin
    rq_ok     = rd_hit && (rd_qidx < ADDR_W'(num_q_i)) && (rd_qidx < ADDR_W'(NUM_Q));
    rtgt      = rd_qidx[QIDX_W-1:0];
    rd_data_o = '0;
    if (rq_ok) rd_data_o = 32'((rd_kind == SLOT_CQ) ? cq_head[rtgt] : sq_tail[rtgt]);
  end

  // Per-pair sizes and rings
  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    if (q == 0) begin : g_admin
      assign sq_size[q] = asq_size_i;
      assign cq_size[q] = acq_size_i;
      assign clr[q]     = 1'b0;
    end else begin : g_io
      logic [PTR_W-1:0] sq_size_q, cq_size_q;
      assign clr[q] = cfg_we_i && (cfg_qid_i == QIDX_W'(q));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sq_size_q <= '0;
          cq_size_q <= '0;
        end else if (clr[q]) begin
          sq_size_q <= cfg_sq_size_i;
          cq_size_q <= cfg_cq_size_i;
        end
      end
      assign sq_size[q] = sq_size_q;
      assign cq_size[q] = cq_size_q;
    end

    dbl_ring #(.PTR_W(PTR_W), .HOST_PROD(1'b1)) u_sq (
      .clk_i, .rst_ni,
      .size_i    (sq_size[q]),
      .clr_i     (clr[q]),
      .host_we_i (wr_good && wr_kind == SLOT_SQ && wtgt == QIDX_W'(q)),
      .host_val_i(wr_data_i[PTR_W-1:0]),
      .step_i    (sq_fetch_i[q]),
      .host_ptr_o(sq_tail[q]),
      .used_o    (sq_pending_o[q]));

    dbl_ring #(.PTR_W(PTR_W), .HOST_PROD(1'b0)) u_cq (
      .clk_i, .rst_ni,
      .size_i    (cq_size[q]),
      .clr_i     (clr[q]),
      .host_we_i (wr_good && wr_kind == SLOT_CQ && wtgt == QIDX_W'(q)),
      .host_val_i(wr_data_i[PTR_W-1:0]),
      .step_i    (cq_post_i[q]),
      .host_ptr_o(cq_head[q]),
      .used_o    (cq_used[q]));

    assign cq_free_o[q] = {1'b0, cq_size[q]} - cq_used[q];
  end

  // R6: sticky error
  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R4: write to an inactive pair flags
  a_r4_bad_index_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_hit && wr_qidx >= ADDR_W'(num_q_i) |=> err_o);

  // R5: oversized admin tail value neither lands nor passes silently
  a_r5_bad_value_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_hit && wr_kind == SLOT_SQ && wr_qidx == '0 && num_q_i != '0
    && wr_data_i > 32'(asq_size_i) |=> $stable(sq_tail[0]) && err_o);
endmodule

// File: tb/doorbell_regfile_test.sv
module doorbell_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int NQ   = 4;
  localparam int PW   = 6;
  localparam int AW   = 16;
  localparam int DS   = 1;
  localparam int STR  = 4 << DS;
  localparam int BASE = 4096;
  localparam int QIW  = 2;
  localparam int QCW  = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [QCW-1:0] num_q = 3'd2;
  logic [PW-1:0] asq_size = 6'd7, acq_size = 6'd3;
  logic cfg_we = 1'b0;
  logic [QIW-1:0] cfg_qid = '0;
  logic [PW-1:0] cfg_sq = '0, cfg_cq = '0;
  logic [NQ-1:0] sq_fetch = '0, cq_post = '0;
  logic [NQ-1:0][PW:0] sq_pending, cq_free;
  logic err;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  doorbell_regfile #(.NUM_Q(NQ), .PTR_W(PW), .ADDR_W(AW), .DSTRD(DS)) uut (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .num_q_i(num_q), .asq_size_i(asq_size), .acq_size_i(acq_size),
    .cfg_we_i(cfg_we), .cfg_qid_i(cfg_qid), .cfg_sq_size_i(cfg_sq), .cfg_cq_size_i(cfg_cq),
    .sq_fetch_i(sq_fetch), .cq_post_i(cq_post),
    .sq_pending_o(sq_pending), .cq_free_o(cq_free), .err_o(err));

  int n_chk = 0, n_fail = 0;
  int m_sqt[NQ], m_sqh[NQ], m_cqh[NQ], m_cqt[NQ], m_sqs[NQ], m_cqs[NQ];
  bit m_err;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ssz(int q); return (q == 0) ? int'(asq_size) : m_sqs[q]; endfunction
  function automatic int csz(int q); return (q == 0) ? int'(acq_size) : m_cqs[q]; endfunction
  function automatic int m_pend(int q);
    return (m_sqt[q] - m_sqh[q] + ssz(q) + 1) % (ssz(q) + 1);
  endfunction
  function automatic int m_cused(int q);
    return (m_cqt[q] - m_cqh[q] + csz(q) + 1) % (csz(q) + 1);
  endfunction

  function automatic void dec(int a, output bit hit, output int qi, output bit is_cq);
    int slot;
    hit = (a >= BASE) && (((a - BASE) % STR) == 0);
    slot = (a - BASE) / STR;
    qi = slot / 2;
    is_cq = (slot % 2) == 1;
  endfunction

  function automatic int m_rd();
    bit hit, is_cq; int qi;
    dec(int'(rd_addr), hit, qi, is_cq);
    if (hit && qi < int'(num_q) && qi < NQ) return is_cq ? m_cqh[qi] : m_sqt[qi];
    return 0;
  endfunction

  task automatic m_clear();
    for (int q = 0; q < NQ; q++) begin
      m_sqt[q] = 0; m_sqh[q] = 0; m_cqh[q] = 0; m_cqt[q] = 0; m_sqs[q] = 0; m_cqs[q] = 0;
    end
    m_err = 1'b0;
  endtask

  task automatic m_update();
    int pend[NQ], used[NQ];
    bit hit, is_cq; int qi;
    for (int q = 0; q < NQ; q++) begin pend[q] = m_pend(q); used[q] = m_cused(q); end
    dec(int'(wr_addr), hit, qi, is_cq);
    if (wr_en && hit) begin
      if (qi < int'(num_q) && qi < NQ &&
          longint'(wr_data) < longint'((is_cq ? csz(qi) : ssz(qi)) + 1)) begin
        if (!(cfg_we && int'(cfg_qid) == qi && qi != 0)) begin
          if (is_cq) m_cqh[qi] = int'(wr_data); else m_sqt[qi] = int'(wr_data);
        end
      end else m_err = 1'b1;
    end
    for (int q = 0; q < NQ; q++) begin
      if (cfg_we && int'(cfg_qid) == q && q != 0) begin
        m_sqs[q] = int'(cfg_sq); m_cqs[q] = int'(cfg_cq);
        m_sqt[q] = 0; m_sqh[q] = 0; m_cqh[q] = 0; m_cqt[q] = 0;
      end else begin
        if (sq_fetch[q] && pend[q] != 0) m_sqh[q] = (m_sqh[q] == ssz(q)) ? 0 : m_sqh[q] + 1;
        if (cq_post[q] && used[q] < csz(q)) m_cqt[q] = (m_cqt[q] == csz(q)) ? 0 : m_cqt[q] + 1;
      end
    end
  endtask

  task automatic compare();
    for (int q = 0; q < NQ; q++) begin
      chk("R7 pending", int'(sq_pending[q]), m_pend(q));
      chk("R9 free", int'(cq_free[q]), csz(q) - m_cused(q));
    end
    chk("R6 err", int'(err), int'(m_err));
    chk("R12 read", int'(rd_data), m_rd());
  endtask

  task automatic tick();
    @(posedge clk_i);
    m_update();
    @(negedge clk_i);
    compare();
    wr_en = 1'b0; cfg_we = 1'b0; sq_fetch = '0; cq_post = '0;
  endtask

  task automatic wr(int a, int v);
    wr_addr = AW'(a); wr_data = 32'(v); wr_en = 1'b1; rd_addr = AW'(a);
    tick();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_clear();
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    m_clear();
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    compare();
    chk("R1 reset pending", int'(sq_pending[0]), 0);
    chk("R1 reset free", int'(cq_free[0]), 3);
    chk("R1 reset err", int'(err), 0);

    wr(BASE, 5);
    chk("R2 sq tail slot", int'(sq_pending[0]), 5);
    chk("R2 sq tail read", int'(rd_data), 5);
    wr(BASE + 4, 1);                       // unscaled offset: not a slot
    rd_addr = AW'(BASE + STR); tick();
    chk("R3 misaligned ignored", int'(rd_data), 0);
    chk("R3 no error", int'(err), 0);
    wr(BASE - STR, 3);
    chk("R3 below region", int'(err), 0);

    sq_fetch[0] = 1'b1; tick();
    sq_fetch[0] = 1'b1; tick();
    chk("R8 fetch", int'(sq_pending[0]), 3);

    for (int i = 0; i < 4; i++) begin cq_post[0] = 1'b1; tick(); end
    chk("R9 full ignores post", int'(cq_free[0]), 0);
    wr(BASE + STR, 2);
    chk("R10 head release", int'(cq_free[0]), 2);

    wr(BASE, 1);
    chk("R7 wrap", int'(sq_pending[0]), 7);
    for (int i = 0; i < 9; i++) begin sq_fetch[0] = 1'b1; tick(); end
    chk("R8 empty ignores fetch", int'(sq_pending[0]), 0);

    cfg_we = 1'b1; cfg_qid = 2'd1; cfg_sq = 6'd15; cfg_cq = 6'd9; tick();
    wr(BASE + 2 * STR, 15);
    chk("R11 io size", int'(sq_pending[1]), 15);
    chk("R11 io cq size", int'(cq_free[1]), 9);
    wr(BASE + 2 * STR, 16);
    chk("R5 value error", int'(err), 1);
    chk("R5 no update", int'(sq_pending[1]), 15);
    tick(); tick();
    chk("R6 sticky", int'(err), 1);

    do_reset();
    chk("R1 err cleared", int'(err), 0);
    chk("R1 size cleared", int'(cq_free[1]), 0);
    wr(BASE + 4 * STR, 0);
    chk("R4 index error", int'(err), 1);
    rd_addr = AW'(BASE + 4 * STR); tick();
    chk("R12 inactive read", int'(rd_data), 0);

    do_reset();
    cfg_we = 1'b1; cfg_qid = 2'd0; cfg_sq = 6'd2; cfg_cq = 6'd1; tick();
    wr(BASE, 5);
    chk("R11 admin cfg ignored", int'(sq_pending[0]), 5);
    chk("R11 admin no error", int'(err), 0);

    do_reset();
    num_q = 3'd3;
    cfg_we = 1'b1; cfg_qid = 2'd1; cfg_sq = 6'd12; cfg_cq = 6'd5; tick();
    cfg_we = 1'b1; cfg_qid = 2'd2; cfg_sq = 6'd3;  cfg_cq = 6'd17; tick();
    r = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      case (r[1:0])
        2'd0: begin wr_en = 1'b1; wr_addr = AW'(BASE + 2 * STR * int'(r[3:2])); end
        2'd1: begin wr_en = 1'b1; wr_addr = AW'(BASE + (2 * int'(r[3:2]) + 1) * STR); end
        2'd2: begin wr_en = 1'b1; wr_addr = AW'(BASE + 4 * int'(r[5:2])); end
        default: wr_en = 1'b0;
      endcase
      wr_data  = 32'(int'(r[12:8]) % 20);
      sq_fetch = r[19:16];
      cq_post  = r[23:20];
      rd_addr  = AW'(BASE + 4 * int'(r[29:24]));
      tick();
      if (i == 300) do_reset();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule